// File: doc/BRIEF.md
# Bidirectional Byte FIFO with Holding Pipeline and Status

This block buffers bytes between a parallel-port engine and a host/DMA engine. A 64-entry byte store sits on the port side. A two-stage holding pipeline sits between the store and the host. The direction input picks which way bytes flow.

When receiving, the port side writes into the store, and bytes then move on their own through the two holding stages. The host reads from the stage nearest to it. When transmitting, the host writes into that near stage, bytes move back through the pipeline into the store, and the port side reads from the store. Every byte carries a tag bit along its whole path.

The block reports a quantity count and an 8-bit status byte. The status byte shows fill state, inactivity (stale) and a sticky timeout. It also shows whether the pipeline holds data or a tagged byte, a sticky data-error flag and a one-byte-left flag. The host interrupt is raised by a tagged byte when the tag interrupt is enabled.

Top module: `bidir_pipe_fifo`

## Requirements
- R1: The store holds at most 64 bytes. Status bit 7 is 1 exactly when it holds 64. A port write in receive mode while full is dropped and leaves the store unchanged.
- R2: `qty` equals the number of bytes in the store when `dir`=0, and 64 minus that number when `dir`=1. Bytes in the two holding stages are never counted.
- R3: After `rst_n` low or a cycle with `fifo_rst`=1, the store and both holding stages are empty and tags are cleared. `status` reads 0x40, and `qty` reads 0x00 in receive or 0x40 in transmit.
- R4: Status bit positions: 7 full, 6 store empty, 5 timeout, 4 holding tag, 3 holding data, 2 stale, 1 data error, 0 one byte left. Bits 7 and 6 are never both set.
- R5: In receive (`dir`=0), bytes written at the port reach `host_rdata`/`host_rtag` in write order. Bit 3 is set while either holding stage holds a byte, and a `host_rd` pulse consumes the byte shown.
- R6: In transmit (`dir`=1), bytes written by the host reach `port_rdata`/`port_rtag` in write order, and a `port_rd` pulse consumes the byte shown.
- R7: Bit 2 (stale) is set once data has sat anywhere in the block for `STALE_CYCLES` consecutive cycles with no accepted host or port transfer. It clears on an accepted transfer or a FIFO reset.
- R8: Bit 5 (timeout) is set by a 0-to-1 change of stale. In transmit it is set on the clock after stale rises. Once set, it stays set until cleared.
- R9: In receive, setting timeout waits until the store is empty and `dma_busy` is low.
- R10: Timeout clears on any change of `clr_to` between clocks, or on a FIFO reset.
- R11: Bit 4 is set while either holding stage holds a tagged byte. `irq` equals bit 4 ANDed with `tag_en`.
- R12: Writing when there is no room, or reading when there is nothing to read, is ignored and sets bit 1 until the next FIFO reset. Bit 0 is set when exactly one byte is held across the store and both holding stages.
- R13: Strobes for the inactive direction (`port_rd`/`host_wr` in receive, `port_wr`/`host_rd` in transmit) are ignored and set no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous device reset, active low |
| dir | input | 1 | 0 receive, 1 transmit; change it together with `fifo_rst` |
| fifo_rst | input | 1 | Synchronous FIFO reset |
| clr_to | input | 1 | Timeout clear; any change clears the timeout |
| tag_en | input | 1 | Tag interrupt enable |
| dma_busy | input | 1 | High while a host/DMA cycle is outstanding |
| port_wr | input | 1 | Port-side write strobe (receive) |
| port_wdata | input | 8 | Port-side write byte |
| port_wtag | input | 1 | Tag for the port-side write byte |
| port_rd | input | 1 | Port-side read strobe (transmit) |
| port_rdata | output | 8 | Oldest byte in the store |
| port_rtag | output | 1 | Tag of the oldest byte in the store |
| host_wr | input | 1 | Host-side write strobe (transmit) |
| host_wdata | input | 8 | Host-side write byte |
| host_wtag | input | 1 | Tag for the host-side write byte |
| host_rd | input | 1 | Host-side read strobe (receive) |
| host_rdata | output | 8 | Byte in the holding stage nearest the host |
| host_rtag | output | 1 | Tag of that byte |
| qty | output | 7 | Direction-dependent quantity count |
| status | output | 8 | Status byte |
| irq | output | 1 | Host interrupt |

## Verification
Every state change lands on the clock edge that samples the stimulus. `qty`, `status`, `irq` and the data outputs are combinational from registers, so each result can be read half a cycle after that edge. Two results follow later. Timeout appears one edge after stale rises, or in receive one edge after the store is empty and `dma_busy` is low. A received byte needs one edge per stage to reach the host. The bench drives inputs on the falling edge and updates a queue-based reference model on the rising edge. It compares all outputs on the next falling edge, so every expected value is due at the exact cycle the design should produce it.

// File: rtl/bidir_pipe_fifo.sv
module bidir_pipe_fifo #(
  parameter int DEPTH = 64,
  parameter int W = 8,
  parameter int STALE_CYCLES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dir,
  input  logic                       fifo_rst,
  input  logic                       clr_to,
  input  logic                       tag_en,
  input  logic                       dma_busy,
  input  logic                       port_wr,
  input  logic [W-1:0]               port_wdata,
  input  logic                       port_wtag,
  input  logic                       port_rd,
  output logic [W-1:0]               port_rdata,
  output logic                       port_rtag,
  input  logic                       host_wr,
  input  logic [W-1:0]               host_wdata,
  input  logic                       host_wtag,
  input  logic                       host_rd,
  output logic [W-1:0]               host_rdata,
  output logic                       host_rtag,
  output logic [$clog2(DEPTH):0]     qty,
  output logic [7:0]                 status,
  output logic                       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int IW = $clog2(STALE_CYCLES + 1);

  logic [W:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [W:0]    hr0, hr1;
  logic          hr0v, hr1v;
  logic [IW-1:0] idle;
  logic          stale_q, pend, tmo, err, clr_q;

  logic          full, empty, stale, htag, hdat;
  logic [CW:0]   total;
  logic [W:0]    head, push_d;
  logic          rd_ok, mv10, mvf0, wr_ok, mv0f, mv10t, hw_ok, prd_ok;
  logic          push, pop, bad, act, rise, fire, clr_tgl;

  assign full  = cnt == CW'(DEPTH);
  assign empty = cnt == '0;
  assign total = {1'b0, cnt} + (CW+1)'(hr0v) + (CW+1)'(hr1v);
  assign stale = (total != '0) && (idle == IW'(STALE_CYCLES));
  assign head  = mem[rptr];

  // receive: store -> hr0 -> hr1 -> host
  assign rd_ok  = !dir & host_rd & hr1v;
  assign mv10   = !dir & hr0v & (!hr1v | rd_ok);
  assign mvf0   = !dir & !empty & (!hr0v | mv10);
  assign wr_ok  = !dir & port_wr & !full;
  // transmit: host -> hr1 -> hr0 -> store
  assign mv0f   = dir & hr0v & !full;
  assign mv10t  = dir & hr1v & (!hr0v | mv0f);
  assign hw_ok  = dir & host_wr & (!hr1v | mv10t);
  assign prd_ok = dir & port_rd & !empty;

  assign push   = wr_ok | mv0f;
  assign pop    = mvf0 | prd_ok;
  assign push_d = dir ? hr0 : {port_wtag, port_wdata};
  assign bad    = (!dir & ((port_wr & full) | (host_rd & !hr1v))) |
                  ( dir & ((host_wr & !hw_ok) | (port_rd & empty)));
  assign act    = wr_ok | rd_ok | hw_ok | prd_ok;
  assign rise   = stale & !stale_q;
  assign clr_tgl = clr_to ^ clr_q;
  assign fire   = (pend | rise) & (dir | (empty & !dma_busy));

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; cnt <= '0;
    end else if (fifo_rst) begin
      wptr <= '0; rptr <= '0; cnt <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hr0 <= '0; hr1 <= '0; hr0v <= 1'b0; hr1v <= 1'b0;
    end else if (fifo_rst) begin
      hr0 <= '0; hr1 <= '0; hr0v <= 1'b0; hr1v <= 1'b0;
    end else if (!dir) begin
      if (mv10) hr1 <= hr0;
      if (mvf0) hr0 <= head;
      hr1v <= mv10 | (hr1v & !rd_ok);
      hr0v <= mvf0 | (hr0v & !mv10);
    end else begin
      if (hw_ok) hr1 <= {host_wtag, host_wdata};
      if (mv10t) hr0 <= hr1;
      hr1v <= hw_ok | (hr1v & !mv10t);
      hr0v <= mv10t | (hr0v & !mv0f);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle <= '0; stale_q <= 1'b0; pend <= 1'b0; tmo <= 1'b0;
      err <= 1'b0; clr_q <= 1'b0;
    end else begin
      clr_q <= clr_to;
      if (fifo_rst) begin
        idle <= '0; stale_q <= 1'b0; pend <= 1'b0; tmo <= 1'b0; err <= 1'b0;
      end else begin
        stale_q <= stale;
        if (bad) err <= 1'b1;
        if (act || total == '0) idle <= '0;
        else if (idle != IW'(STALE_CYCLES)) idle <= idle + 1'b1;
        if (clr_tgl) begin
          tmo <= 1'b0; pend <= 1'b0;
        end else if (fire) begin
          tmo <= 1'b1; pend <= 1'b0;
        end else if (rise) begin
          pend <= 1'b1;
        end
      end
    end
  end

  assign htag = (hr0v & hr0[W]) | (hr1v & hr1[W]);
  assign hdat = hr0v | hr1v;

  assign port_rdata = head[W-1:0];
  assign port_rtag  = head[W];
  assign host_rdata = hr1[W-1:0];
  assign host_rtag  = hr1[W];
  assign qty        = dir ? CW'(DEPTH) - cnt : cnt;
  assign status     = {full, empty, tmo, htag, hdat, stale, err, total == (CW+1)'(1)};
  assign irq        = tag_en & htag;
endmodule

// File: rtl/bidir_pipe_fifo_chk.sv
module bidir_pipe_fifo_chk #(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   dir,
  input logic                   fifo_rst,
  input logic                   clr_to,
  input logic                   dma_busy,
  input logic [$clog2(DEPTH):0] qty,
  input logic [7:0]             status,
  input logic                   irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  // R2
  qty_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qty <= CW'(DEPTH));

  // R4
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[6]));

  // R3
  fifo_rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> status == 8'h40);

  // R11
  irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[3]);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] && !fifo_rst |=> status[1]);

  // R10
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] && !fifo_rst && (clr_to == $past(clr_to)) |=> status[5]);

  // R9
  rx_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir && !status[5] && dma_busy |=> !status[5]);
endmodule

bind bidir_pipe_fifo bidir_pipe_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir(dir), .fifo_rst(fifo_rst), .clr_to(clr_to),
  .dma_busy(dma_busy), .qty(qty), .status(status), .irq(irq)
);

// File: tb/bidir_pipe_fifo_tb.sv
module bidir_pipe_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int STALE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir = 1'b0, fifo_rst = 1'b0, clr_to = 1'b0, tag_en = 1'b0, dma_busy = 1'b0;
  logic port_wr = 1'b0, port_wtag = 1'b0, port_rd = 1'b0;
  logic host_wr = 1'b0, host_wtag = 1'b0, host_rd = 1'b0;
  logic [7:0] port_wdata = '0, host_wdata = '0;
  logic [7:0] port_rdata, host_rdata, status;
  logic port_rtag, host_rtag, irq;
  logic [6:0] qty;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_pipe_fifo #(.DEPTH(DEPTH), .W(8), .STALE_CYCLES(STALE)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir(dir), .fifo_rst(fifo_rst), .clr_to(clr_to),
    .tag_en(tag_en), .dma_busy(dma_busy),
    .port_wr(port_wr), .port_wdata(port_wdata), .port_wtag(port_wtag),
    .port_rd(port_rd), .port_rdata(port_rdata), .port_rtag(port_rtag),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_wtag(host_wtag),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_rtag(host_rtag),
    .qty(qty), .status(status), .irq(irq)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit compare_on = 0;

  // reference model state
  int q[$];
  int h0, h1;
  bit h0v, h1v;
  int idle;
  bit st_q, pend, tmo, err, clrq;
  int cnt, tot;
  bit stale, rise, fire, tgl, rd_ok, mv10, mvf0, wr_ok, mv0f, mv10t, hw_ok, prd_ok, bad, act;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); h0v = 0; h1v = 0; h0 = 0; h1 = 0; idle = 0;
      st_q = 0; pend = 0; tmo = 0; err = 0; clrq = 0;
    end else begin
      cnt = q.size(); tot = cnt + h0v + h1v;
      stale = (tot != 0) && (idle == STALE);
      tgl = clr_to != clrq;
      clrq = clr_to;
      if (fifo_rst) begin
        q.delete(); h0v = 0; h1v = 0; h0 = 0; h1 = 0; idle = 0;
        st_q = 0; pend = 0; tmo = 0; err = 0;
      end else begin
        rd_ok = 0; mv10 = 0; mvf0 = 0; wr_ok = 0; mv0f = 0; mv10t = 0; hw_ok = 0; prd_ok = 0;
        if (!dir) begin
          rd_ok = host_rd && h1v;
          mv10 = h0v && (!h1v || rd_ok);
          mvf0 = (cnt != 0) && (!h0v || mv10);
          wr_ok = port_wr && (cnt != DEPTH);
          bad = (port_wr && cnt == DEPTH) || (host_rd && !h1v);
          if (rd_ok) h1v = 0;
          if (mv10) begin h1 = h0; h1v = 1; h0v = 0; end
          if (mvf0) begin h0 = q.pop_front(); h0v = 1; end
          if (wr_ok) q.push_back({port_wtag, port_wdata});
        end else begin
          mv0f = h0v && (cnt != DEPTH);
          mv10t = h1v && (!h0v || mv0f);
          hw_ok = host_wr && (!h1v || mv10t);
          prd_ok = port_rd && (cnt != 0);
          bad = (host_wr && !hw_ok) || (port_rd && cnt == 0);
          if (prd_ok) void'(q.pop_front());
          if (mv0f) begin q.push_back(h0); h0v = 0; end
          if (mv10t) begin h0 = h1; h0v = 1; h1v = 0; end
          if (hw_ok) begin h1 = {host_wtag, host_wdata}; h1v = 1; end
        end
        act = wr_ok || rd_ok || hw_ok || prd_ok;
        rise = stale && !st_q;
        fire = (pend || rise) && (dir || (cnt == 0 && !dma_busy));
        st_q = stale;
        if (bad) err = 1;
        if (act || tot == 0) idle = 0;
        else if (idle != STALE) idle = idle + 1;
        if (tgl) begin tmo = 0; pend = 0; end
        else if (fire) begin tmo = 1; pend = 0; end
        else if (rise) pend = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic compare();
    int n = q.size();
    int t = n + h0v + h1v;
    bit st_now = (t != 0) && (idle == STALE);
    bit htag = (h0v && h0[8]) || (h1v && h1[8]);
    int eq = dir ? DEPTH - n : n;
    check(qty == eq, "R2", "qty", qty, eq);
    check(status[7] == (n == DEPTH), "R1", "full bit", status[7], n == DEPTH);
    check(status[6] == (n == 0), "R4", "empty bit", status[6], n == 0);
    check(status[5] == tmo, "R8", "timeout bit", status[5], tmo);
    check(status[4] == htag, "R11", "tag bit", status[4], htag);
    check(status[3] == (h0v || h1v), "R5", "holding data bit", status[3], h0v || h1v);
    check(status[2] == st_now, "R7", "stale bit", status[2], st_now);
    check(status[1] == err, "R12", "error bit", status[1], err);
    check(status[0] == (t == 1), "R12", "one byte bit", status[0], t == 1);
    check(irq == (tag_en && htag), "R11", "irq", irq, tag_en && htag);
    if (!dir && h1v)
      check({host_rtag, host_rdata} == 9'(h1), "R5", "host data", {host_rtag, host_rdata}, h1);
    if (dir && n > 0)
      check({port_rtag, port_rdata} == 9'(q[0]), "R6", "port data", {port_rtag, port_rdata}, q[0]);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (compare_on) compare();
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic fifo_reset(input bit d);
    dir = d; fifo_rst = 1; tick(); fifo_rst = 0;
  endtask

  task automatic pwrite(input logic [7:0] d, input bit tg);
    port_wr = 1; port_wdata = d; port_wtag = tg; tick(); port_wr = 0; port_wtag = 0;
  endtask

  task automatic hwrite(input logic [7:0] d, input bit tg);
    host_wr = 1; host_wdata = d; host_wtag = tg; tick(); host_wr = 0; host_wtag = 0;
  endtask

  task automatic hread();
    host_rd = 1; tick(); host_rd = 0;
  endtask

  task automatic pread();
    port_rd = 1; tick(); port_rd = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    logic [6:0] q_before;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    compare_on = 1;
    // R3: reset state
    check(status == 8'h40, "R3", "status after reset", status, 8'h40);
    check(qty == 7'h00, "R3", "qty after reset rx", qty, 0);

    // R5 receive order with tags, R11 irq
    tag_en = 1;
    pwrite(8'h11, 0); pwrite(8'h22, 0); pwrite(8'h33, 1); pwrite(8'h44, 0); pwrite(8'h55, 0);
    idle_n(3);
    check(host_rdata == 8'h11, "R5", "first byte at host", host_rdata, 8'h11);
    check(qty == 7'd3, "R2", "qty excludes holding stages", qty, 3);
    for (int i = 0; i < 5; i++) begin hread(); tick(); end
    // R12 underflow
    hread();
    check(status[1] == 1'b1, "R12", "error after empty read", status[1], 1);
    // R13 wrong-direction strobes in receive
    fifo_reset(0);
    pwrite(8'h5a, 0); idle_n(2);
    q_before = qty;
    hwrite(8'hee, 0); pread();
    check(qty == q_before, "R13", "qty after ignored strobes", qty, q_before);
    check(status[1] == 1'b0, "R13", "no error from ignored strobes", status[1], 0);
    check(host_rdata == 8'h5a, "R13", "holding byte kept", host_rdata, 8'h5a);

    // R1 overflow in receive
    fifo_reset(0);
    for (int i = 0; i < 70; i++) pwrite(8'(i), i[0]);
    check(qty == 7'd64, "R1", "qty when full", qty, 64);
    check(status[7] == 1'b1, "R1", "full bit", status[7], 1);
    check(status[1] == 1'b1, "R12", "error after overflow", status[1], 1);
    for (int i = 0; i < 66; i++) hread();
    idle_n(2);

    // R9 deferred timeout in receive
    fifo_reset(0);
    dma_busy = 1;
    pwrite(8'ha1, 0); pwrite(8'ha2, 0); pwrite(8'ha3, 0);
    idle_n(STALE + 4);
    check(status[2] == 1'b1, "R7", "stale after idle", status[2], 1);
    check(status[5] == 1'b0, "R9", "timeout held while store non-empty", status[5], 0);
    hread();
    check(status[2] == 1'b0, "R7", "stale cleared by transfer", status[2], 0);
    idle_n(STALE + 4);
    check(status[5] == 1'b0, "R9", "timeout held while DMA busy", status[5], 0);
    dma_busy = 0;
    idle_n(2);
    check(status[5] == 1'b1, "R9", "timeout after DMA idle", status[5], 1);
    idle_n(3);
    clr_to = ~clr_to; tick();
    check(status[5] == 1'b0, "R10", "timeout cleared by toggle", status[5], 0);

    // R6 transmit order, R2 free space
    fifo_reset(1);
    check(qty == 7'h40, "R3", "qty after reset tx", qty, 7'h40);
    check(status == 8'h40, "R3", "status after reset tx", status, 8'h40);
    for (int i = 0; i < 10; i++) hwrite(8'(8'h80 + i), (i == 4));
    idle_n(3);
    check(qty == 7'd54, "R2", "free space tx", qty, 54);
    check(port_rdata == 8'h80, "R6", "first byte at port", port_rdata, 8'h80);
    q_before = qty;
    pwrite(8'h77, 0); hread();
    check(qty == q_before, "R13", "qty after ignored strobes tx", qty, q_before);
    for (int i = 0; i < 10; i++) pread();
    pread();
    check(status[1] == 1'b1, "R12", "error after empty port read", status[1], 1);

    // R8 transmit timeout
    fifo_reset(1);
    hwrite(8'hc1, 0); hwrite(8'hc2, 0);
    idle_n(STALE + 4);
    check(status[5] == 1'b1, "R8", "timeout in transmit", status[5], 1);
    fifo_reset(1);
    check(status[5] == 1'b0, "R10", "timeout cleared by fifo reset", status[5], 0);

    // overflow in transmit
    for (int i = 0; i < 70; i++) hwrite(8'(i), 0);
    check(status[7] == 1'b1, "R1", "full in transmit", status[7], 1);
    check(status[1] == 1'b1, "R12", "error after host overflow", status[1], 1);
    for (int i = 0; i < 67; i++) pread();
    idle_n(2);
    finish_run();
  end
endmodule